// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This controller sequences sleep entry and wake-up for a small microcontroller core. When the core executes its sleep instruction it pulses `sleep_cmd`. If `sleep_en` is set at that moment, the controller latches the three-bit `sleep_mode` code and then drives the gate enables for five clock domains and the oscillator enable to match that mode. It also holds the core halted. Entering Idle or ADC Noise Reduction with the converter enabled produces a single conversion-start pulse.

While asleep, the controller watches the pending-and-enabled interrupt lines. Power-down accepts only a configured subset of these lines as wake sources. After a wake, the controller keeps the core halted for an oscillator start-up interval and then for four more cycles. Only after that does it release the core and flag that the interrupt path must be taken. A reset request that arrives during sleep or during the wake sequence ends the sequence on the next cycle, with no interrupt indication.

The controller has four states:
- `ST_RUN`: the core is awake.
- `ST_SLEEP`: the domains are gated.
- `ST_STARTUP`: the oscillator is settling.
- `ST_HOLD`: four fixed cycles with all clocks on while the core is still halted.

It has these transitions:
- RUN to SLEEP on an accepted sleep command.
- SLEEP to STARTUP, or directly to HOLD when the start-up length is zero, on a wake.
- STARTUP to HOLD when its count expires.
- HOLD to RUN when its count expires.
- Any other state to RUN on `rst_req`.

Top module: `slp_ctrl_top`

## Requirements
- R1: A `sleep_cmd` pulse sampled while `sleep_en`=0 is ignored. All outputs stay at their awake values.
- R2: While awake, every clock enable and `osc_en` are 1, and `core_halt` is 0. This is also the state after `rst_n`.
- R3: The cycle after an accepted command, the enables {cpu,flash,io,adc,pll,osc} take these values:
  - 000 (Idle): 001111.
  - 001 (ADC Noise Reduction): 000101.
  - 010 (Power-down): 000000.
  - 110 (Standby): 000001.
  - Any other code behaves as Idle.
- R4: Sleep ends when any line has both `irq_req` and `irq_en` set. In Power-down, only lines set in PD_WAKE_MASK count. The default mask 8'h8F allows lines 0 to 3 and line 7.
- R5: After the edge that samples the wake, `core_halt` stays 1 for S+4 cycles. S is STARTUP_CYC (default 6) for Power-down and Standby, and 0 for the other modes. During the first S cycles the sleep pattern holds with `osc_en`=1. During the last 4 cycles all enables are 1.
- R6: `wake_irq` is a one-cycle pulse. It is given in the first cycle that `core_halt` is 0 after a wake.
- R7: `rst_req` sampled in any state other than awake returns the block to the awake state on the next cycle, with no `wake_irq`. This holds even when a wake is pending in the same cycle.
- R8: `adc_start` pulses for one cycle, together with sleep entry, when `adc_en`=1 and the mode behaves as Idle or ADC Noise Reduction. It never pulses otherwise.
- R9: The enables are registered and change only on state transitions. They stay stable for as long as the block stays asleep.
- R10: A `sleep_cmd` arriving while the core is halted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Chip reset event; cancels sleep or wake |
| sleep_en | input | 1 | Sleep permission bit |
| sleep_mode | input | 3 | Sleep mode code |
| sleep_cmd | input | 1 | One-cycle pulse from the sleep instruction |
| irq_req | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enables |
| adc_en | input | 1 | Converter enabled |
| clk_cpu_en | output | 1 | CPU clock gate enable |
| clk_flash_en | output | 1 | Flash clock gate enable |
| clk_io_en | output | 1 | I/O clock gate enable |
| clk_adc_en | output | 1 | ADC clock gate enable |
| clk_pll_en | output | 1 | PLL clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| core_halt | output | 1 | Core held halted |
| wake_irq | output | 1 | Pulse: resume through the interrupt path |
| adc_start | output | 1 | Pulse: automatic conversion start |

## Verification
The bench measures the halt window cycle by cycle after each wake, for both zero and non-zero start-up lengths. A design that miscounts would release the core early or late, or would raise `wake_irq` in the wrong cycle. It drives a wake and a reset in the same cycle, to expose a design that lets the interrupt path win. It also offers masked lines during Power-down, to expose a design that wakes on an edge-type source. Finally, it pulses the sleep command with `sleep_en` clear and also while already asleep, and reserved codes are drawn at random, so that a design that decodes them as Power-down would visibly stop the I/O clock.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_STARTUP = 2'd2,
        ST_HOLD    = 2'd3
    } slp_state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic pll;
        logic osc;
    } clk_gate_t;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_ANR   = 3'b001;
    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_STBY  = 3'b110;

    localparam clk_gate_t GATES_AWAKE = '{cpu: 1'b1, flash: 1'b1, io: 1'b1,
                                          adc: 1'b1, pll: 1'b1, osc: 1'b1};
endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
    import slp_pkg::*;
(
    input  logic [2:0] mode,
    output clk_gate_t  gates,
    output logic       long_start,
    output logic       adc_trig_ok,
    output logic       pd_sel
);
    always_comb begin
        gates       = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, pll: 1'b1, osc: 1'b1};
        long_start  = 1'b0;
        adc_trig_ok = 1'b1;
        pd_sel      = 1'b0;
        unique case (mode)
            MODE_ANR: begin
                gates = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, pll: 1'b0, osc: 1'b1};
            end
            MODE_PDOWN: begin
                gates       = '{default: 1'b0};
                long_start  = 1'b1;
                adc_trig_ok = 1'b0;
                pd_sel      = 1'b1;
            end
            MODE_STBY: begin
                gates       = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, pll: 1'b0, osc: 1'b1};
                long_start  = 1'b1;
                adc_trig_ok = 1'b0;
            end
            default: begin
                // Idle and every reserved code keep the Idle pattern set above
            end
        endcase
    end
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter #(
    parameter int               N_IRQ        = 8,
    parameter logic [N_IRQ-1:0] PD_WAKE_MASK = 8'h8F
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             pd_sel,
    output logic             wake
);
    logic [N_IRQ-1:0] live;
    logic [N_IRQ-1:0] mask;

    always_comb begin
        mask = pd_sel ? PD_WAKE_MASK : {N_IRQ{1'b1}};
        live = irq_req & irq_en & mask;
        wake = |live;
    end
endmodule

// File: rtl/slp_halt_timer.sv
module slp_halt_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/slp_ctrl_top.sv
module slp_ctrl_top
    import slp_pkg::*;
#(
    parameter int               N_IRQ        = 8,
    parameter logic [N_IRQ-1:0] PD_WAKE_MASK = 8'h8F,
    parameter int               STARTUP_CYC  = 6,
    parameter int               HOLD_CYC     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             sleep_en,
    input  logic [2:0]       sleep_mode,
    input  logic             sleep_cmd,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             adc_en,
    output logic             clk_cpu_en,
    output logic             clk_flash_en,
    output logic             clk_io_en,
    output logic             clk_adc_en,
    output logic             clk_pll_en,
    output logic             osc_en,
    output logic             core_halt,
    output logic             wake_irq,
    output logic             adc_start
);
    localparam int MAX_CYC = (STARTUP_CYC > HOLD_CYC) ? STARTUP_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] START_LOAD = CNT_W'((STARTUP_CYC > 0) ? STARTUP_CYC - 1 : 0);
    localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'((HOLD_CYC > 0) ? HOLD_CYC - 1 : 0);
    localparam bit HAS_STARTUP = (STARTUP_CYC > 0);

    slp_state_e state_q, state_d;
    logic [2:0] mode_q;
    logic [2:0] mode_sel;
    clk_gate_t  dec_gates, gates_q;
    logic       long_start, adc_trig_ok, pd_sel;
    logic       wake, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic       accept_sleep;
    logic       halt_q, wake_irq_q, adc_start_q;

    assign mode_sel = (state_q == ST_RUN) ? sleep_mode : mode_q;

    slp_mode_decode u_dec (
        .mode        (mode_sel),
        .gates       (dec_gates),
        .long_start  (long_start),
        .adc_trig_ok (adc_trig_ok),
        .pd_sel      (pd_sel)
    );

    slp_wake_filter #(
        .N_IRQ        (N_IRQ),
        .PD_WAKE_MASK (PD_WAKE_MASK)
    ) u_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .pd_sel  (pd_sel),
        .wake    (wake)
    );

    slp_halt_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign accept_sleep = !rst_req && sleep_cmd && sleep_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept_sleep) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (rst_req)   state_d = ST_RUN;
                else if (wake) state_d = (long_start && HAS_STARTUP) ? ST_STARTUP : ST_HOLD;
            end
            ST_STARTUP: begin
                if (rst_req)       state_d = ST_RUN;
                else if (tmr_done) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (rst_req)       state_d = ST_RUN;
                else if (tmr_done) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q) &&
                   ((state_d == ST_STARTUP) || (state_d == ST_HOLD));
        tmr_val  = (state_d == ST_STARTUP) ? START_LOAD : HOLD_LOAD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_IDLE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && state_d == ST_SLEEP) mode_q <= sleep_mode;
        end
    end

    // registered outputs, driven from the next state only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gates_q     <= GATES_AWAKE;
            halt_q      <= 1'b0;
            wake_irq_q  <= 1'b0;
            adc_start_q <= 1'b0;
        end else begin
            unique case (state_d)
                ST_RUN:     gates_q <= GATES_AWAKE;
                ST_SLEEP:   gates_q <= dec_gates;
                ST_STARTUP: begin
                    gates_q     <= dec_gates;
                    gates_q.osc <= 1'b1;
                end
                ST_HOLD:    gates_q <= GATES_AWAKE;
                default:    gates_q <= GATES_AWAKE;
            endcase
            halt_q      <= (state_d != ST_RUN);
            wake_irq_q  <= (state_q == ST_HOLD) && (state_d == ST_RUN) && !rst_req;
            adc_start_q <= (state_q == ST_RUN) && (state_d == ST_SLEEP) && adc_trig_ok && adc_en;
        end
    end

    assign clk_cpu_en   = gates_q.cpu;
    assign clk_flash_en = gates_q.flash;
    assign clk_io_en    = gates_q.io;
    assign clk_adc_en   = gates_q.adc;
    assign clk_pll_en   = gates_q.pll;
    assign osc_en       = gates_q.osc;
    assign core_halt    = halt_q;
    assign wake_irq     = wake_irq_q;
    assign adc_start    = adc_start_q;
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk
    import slp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rst_req,
    input logic       sleep_cmd,
    input logic       sleep_en,
    input logic [5:0] gates,
    input logic       core_halt,
    input logic       wake_irq,
    input logic       adc_start,
    input slp_state_e state
);
    AST_DISABLED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && sleep_cmd && !sleep_en) |=> !core_halt); // R1

    AST_AWAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !core_halt |-> (gates == 6'b111111)); // R2

    AST_CPU_GATED_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        !gates[5] |-> core_halt); // R3

    AST_WAKE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> ($past(core_halt) && !core_halt)); // R6

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq); // R6

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_RUN) && rst_req) |=> (!core_halt && !wake_irq)); // R7

    AST_ADC_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ((state == ST_SLEEP) && ($past(state) == ST_RUN))); // R8

    AST_GATES_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP) && ($past(state) == ST_SLEEP)) |-> $stable(gates)); // R9
endmodule

bind slp_ctrl_top slp_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .sleep_cmd (sleep_cmd),
    .sleep_en  (sleep_en),
    .gates     ({clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_pll_en, osc_en}),
    .core_halt (core_halt),
    .wake_irq  (wake_irq),
    .adc_start (adc_start),
    .state     (state_q)
);

// File: tb/tb_slp_ctrl_top.sv
`timescale 1ns/1ps
module tb_slp_ctrl_top;
    localparam int         N_IRQ  = 8;
    localparam logic [7:0] PDMASK = 8'h8F;
    localparam int         SCYC   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req = 1'b0, sleep_en = 1'b0, sleep_cmd = 1'b0, adc_en = 1'b0;
    logic [2:0] sleep_mode = 3'b000;
    logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
    logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_pll_en, osc_en;
    logic core_halt, wake_irq, adc_start;
    int   n_chk = 0, n_err = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    slp_ctrl_top #(.N_IRQ(N_IRQ), .PD_WAKE_MASK(PDMASK), .STARTUP_CYC(SCYC), .HOLD_CYC(4)) dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .sleep_en(sleep_en),
        .sleep_mode(sleep_mode), .sleep_cmd(sleep_cmd), .irq_req(irq_req),
        .irq_en(irq_en), .adc_en(adc_en), .clk_cpu_en(clk_cpu_en),
        .clk_flash_en(clk_flash_en), .clk_io_en(clk_io_en), .clk_adc_en(clk_adc_en),
        .clk_pll_en(clk_pll_en), .osc_en(osc_en), .core_halt(core_halt),
        .wake_irq(wake_irq), .adc_start(adc_start));

    function automatic logic [5:0] gates_now();
        return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_pll_en, osc_en};
    endfunction

    function automatic logic [5:0] exp_gates(input logic [2:0] m);
        case (m)
            3'b001:  return 6'b000101;
            3'b010:  return 6'b000000;
            3'b110:  return 6'b000001;
            default: return 6'b001111;
        endcase
    endfunction

    function automatic int exp_start(input logic [2:0] m);
        return (m == 3'b010 || m == 3'b110) ? SCYC : 0;
    endfunction

    function automatic logic exp_adc(input logic [2:0] m, input logic a);
        return a && !(m == 3'b010 || m == 3'b110);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic enter(input logic [2:0] m, input logic a);
        @(negedge clk);
        sleep_en = 1'b1; sleep_mode = m; adc_en = a; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        chk("R3 gates on entry", 32'(gates_now()), 32'(exp_gates(m)));
        chk("R3 halt on entry", 32'(core_halt), 32'd1);
        chk("R8 adc_start", 32'(adc_start), 32'(exp_adc(m, a)));
        @(negedge clk);
        chk("R8 adc_start single", 32'(adc_start), 32'd0);
        chk("R9 gates steady", 32'(gates_now()), 32'(exp_gates(m)));
    endtask

    task automatic wake_seq(input logic [2:0] m, input int line);
        int s;
        s = exp_start(m);
        irq_en = '1;
        irq_req = N_IRQ'(1) << line;
        for (int k = 1; k <= s + 4; k++) begin
            @(negedge clk);
            irq_req = '0;
            chk("R5 halt held", 32'(core_halt), 32'd1);
            chk("R6 no early wake_irq", 32'(wake_irq), 32'd0);
            if (k <= s) chk("R5 startup gates", 32'(gates_now()), 32'(exp_gates(m) | 6'b000001));
            else        chk("R5 hold gates", 32'(gates_now()), 32'h3F);
        end
        @(negedge clk);
        chk("R5 halt released", 32'(core_halt), 32'd0);
        chk("R6 wake_irq", 32'(wake_irq), 32'd1);
        chk("R2 gates awake", 32'(gates_now()), 32'h3F);
        @(negedge clk);
        chk("R6 wake_irq single", 32'(wake_irq), 32'd0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
                report();
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset state gates", 32'(gates_now()), 32'h3F);
        chk("R2 reset state halt", 32'(core_halt), 32'd0);

        // R1: disabled sleep request
        sleep_en = 1'b0; sleep_mode = 3'b010; adc_en = 1'b1; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        chk("R1 no entry halt", 32'(core_halt), 32'd0);
        chk("R1 no entry gates", 32'(gates_now()), 32'h3F);
        chk("R1 no adc_start", 32'(adc_start), 32'd0);

        // directed modes
        enter(3'b000, 1'b1); wake_seq(3'b000, 2);
        enter(3'b001, 1'b1); wake_seq(3'b001, 5);
        enter(3'b110, 1'b1); wake_seq(3'b110, 4);

        // R4: power-down ignores masked and disabled lines
        enter(3'b010, 1'b0);
        irq_en = '1; irq_req = 8'h70;
        repeat (3) @(negedge clk);
        chk("R4 masked lines ignored", 32'(core_halt), 32'd1);
        chk("R4 masked gates", 32'(gates_now()), 32'd0);
        irq_req = '0; irq_en = 8'h7F;
        irq_req = 8'h80;
        repeat (2) @(negedge clk);
        chk("R4 disabled line ignored", 32'(core_halt), 32'd1);
        irq_req = '0;
        // R10: command while halted
        sleep_mode = 3'b000; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        chk("R10 cmd while asleep", 32'(gates_now()), 32'd0);
        wake_seq(3'b010, 7);

        // R7: reset and wake in the same cycle
        enter(3'b010, 1'b0);
        irq_en = '1; irq_req = 8'h01; rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0; irq_req = '0;
        chk("R7 reset wins halt", 32'(core_halt), 32'd0);
        chk("R7 reset wins wake_irq", 32'(wake_irq), 32'd0);
        chk("R7 gates awake", 32'(gates_now()), 32'h3F);
        @(negedge clk);
        chk("R7 no late wake_irq", 32'(wake_irq), 32'd0);

        // R7: reset during start-up
        enter(3'b110, 1'b0);
        irq_req = 8'h02;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        chk("R7 reset in startup", 32'(core_halt), 32'd0);
        repeat (6) begin
            @(negedge clk);
            chk("R7 no wake_irq after reset", 32'(wake_irq), 32'd0);
        end

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [2:0] m;
            logic a, en;
            int line;
            m = 3'($urandom_range(0, 7));
            a = 1'($urandom_range(0, 1));
            en = ($urandom_range(0, 3) != 0);
            if (!en) begin
                @(negedge clk);
                sleep_en = 1'b0; sleep_mode = m; sleep_cmd = 1'b1;
                @(negedge clk);
                sleep_cmd = 1'b0;
                chk("R1 random no entry", 32'(core_halt), 32'd0);
            end else begin
                enter(m, a);
                if (m == 3'b010) begin
                    case ($urandom_range(0, 4))
                        0: line = 0; 1: line = 1; 2: line = 2; 3: line = 3;
                        default: line = 7;
                    endcase
                end else line = $urandom_range(0, N_IRQ - 1);
                wake_seq(m, line);
            end
        end
        repeat (2) @(negedge clk);
        report();
    end
endmodule